// File: doc/BRIEF.md
# Receive DMA Double-Buffer Controller

This block moves received bytes of one serial channel from a receive FIFO into two host-supplied memory buffers, A and B, used in ping-pong order. Each buffer has a start address, an exclusive limit address, a current address and an ownership flag. The host grants a buffer by setting its flag. The block then issues bursts of up to 16 bytes on a request/acknowledge/error memory port. It gives the flag back only when the buffer's current address reaches its limit, and then it moves to the other buffer.

Receive timeouts, character exceptions and memory bus errors raise an interrupt and halt transfers. They never release ownership. The host ends the interrupt by writing a command word that can terminate the buffer, discard the exceptional byte, skip a gap, or simply continue. After a bus error the failed burst is not popped from the FIFO. It is therefore written again, either at the same address (continue) or into the other buffer (terminate).

The controller is a four-state machine:
- `S_HOLD`: the active buffer is not owned, so data waits in the FIFO.
- `S_READY`: the active buffer is owned and the block waits for data.
- `S_BURST`: a memory request is outstanding.
- `S_INTR`: the interrupt is raised and the block waits for the command word.

Transitions:
- HOLD→READY when the flag is granted.
- READY→HOLD when the flag is found clear.
- READY→READY on end-of-buffer, which closes the buffer and switches to the other one.
- READY→BURST when data and room exist.
- BURST→READY on acknowledge.
- BURST→INTR on error.
- HOLD/READY→INTR on a pending timeout or exception.
- INTR→READY on the command write.

Top module: `rxdma_dbuf`

## Requirements
- R1: After reset, every readable register reads 0. `irq` and `mem_req` are 0, both buffers are unowned, and A is the active buffer.
- R2: Register indices are as follows.
  - Index 0 is A start and index 4 is B start. A write loads both the start and the current address, and clears the done and error bits.
  - Indices 1 and 5 are the limits (exclusive).
  - Indices 2 and 6 are status: write bit0 = own; read bit0 own, bit1 done, bit2 bus error.
  - Indices 3 and 7 are the current addresses (read-only).
  - Index 8 is the command word.
  - Index 9 is interrupt status: bit0 timeout, bit1 bus error, bit2 exception, bit3 active buffer (1 = B).
- R3: No memory request is made while the active buffer is unowned, even with data in the FIFO.
- R4: A burst starts at the active current address. Its length is min(FIFO level, 16, limit − current). Address and length stay stable until acknowledge or error.
- R5: On acknowledge, the current address advances by the burst length and `fifo_pop` pulses with `fifo_pop_len` equal to that length.
- R6: When the current address equals the limit, the buffer's own bit clears, its done bit sets, and the other buffer becomes active.
- R7: A `rx_timeout` or `rx_exc` pulse sets its status bit and raises `irq`. Transfers halt, and ownership is kept.
- R8: Writing the command word (bit9 terminate, bit8 discard, bits7:0 gap) while `irq` is high ends the interrupt and clears the status bits. A command written while `irq` is low has no effect.
- R9: Terminate closes the active buffer (own cleared, done set) and switches to the other buffer. If that buffer is unowned, transfers stay stopped.
- R10: The discard bit produces a one-cycle `fifo_drop` pulse.
- R11: A nonzero gap advances the current address by that count, clamped at the limit. A zero command continues unchanged.
- R12: On `mem_err`, `irq` rises, status bit1 and the buffer's error bit set, and the current address keeps the failed burst's start. No pop occurs, so the same bytes are sent in the next burst.
- R13: The valid byte count of a buffer is its current address minus its start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Host register index |
| reg_wdata | input | AW | Host write data |
| reg_rdata | output | AW | Host read data (combinational) |
| rx_timeout | input | 1 | Receive timeout pulse |
| rx_exc | input | 1 | Character exception pulse |
| fifo_level | input | LW | Bytes available in the receive FIFO |
| fifo_pop | output | 1 | FIFO pop strobe after a good burst |
| fifo_pop_len | output | LEN_W | Number of bytes popped |
| fifo_drop | output | 1 | Drop one exceptional byte |
| mem_req | output | 1 | Burst request |
| mem_addr | output | AW | Burst start address |
| mem_len | output | LEN_W | Burst length in bytes |
| mem_ack | input | 1 | Burst completed |
| mem_err | input | 1 | Burst failed |
| irq | output | 1 | Interrupt, high in S_INTR |

## Verification
The assertions assume the memory side answers only while `mem_req` is high, with `mem_ack` and `mem_err` never high together. They also assume the host never revokes ownership or rewrites the active buffer while a burst is outstanding, and programs every limit at or above its start. The stimulus respects all of this. The responder task drives acknowledge or error only after it sees the request, and every ownership and address write is made while the FIFO is empty or the active buffer is unowned.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    typedef enum logic [1:0] {S_HOLD, S_READY, S_BURST, S_INTR} rx_state_e;

    localparam int CMD_TERM_BIT = 9;
    localparam int CMD_DISC_BIT = 8;
    localparam logic [3:0] IDX_CMD = 4'h8;
    localparam logic [3:0] IDX_ISR = 4'h9;
endpackage

// File: rtl/rxdma_buf.sv
module rxdma_buf #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_start,
    input  logic          wr_lim,
    input  logic          wr_stat,
    input  logic [AW-1:0] wdata,
    input  logic          adv,
    input  logic [AW-1:0] adv_amt,
    input  logic          close,
    input  logic          set_err,
    output logic          own,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] lim_addr
);
    logic [AW:0] sum;
    logic [AW-1:0] adv_next;

    always_comb begin
        sum = {1'b0, cur_addr} + {1'b0, adv_amt};
        adv_next = (sum > {1'b0, lim_addr}) ? lim_addr : sum[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own <= 1'b0; done <= 1'b0; err <= 1'b0;
            start_addr <= '0; cur_addr <= '0; lim_addr <= '0;
        end else begin
            if (adv) cur_addr <= adv_next;
            if (set_err) err <= 1'b1;
            if (close) begin
                own  <= 1'b0;
                done <= 1'b1;
            end
            if (wr_start) begin
                start_addr <= wdata;
                cur_addr   <= wdata;
                done <= 1'b0;
                err  <= 1'b0;
            end
            if (wr_lim) lim_addr <= wdata;
            if (wr_stat) begin
                own <= wdata[0];
                if (wdata[0]) done <= 1'b0;
            end
        end
    end

    AST_GAP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_start && !wr_lim && cur_addr <= lim_addr) |=> cur_addr <= lim_addr); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (set_err && !wr_start) |=> err); // R12
    AST_CLOSE_DROPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (close && !wr_stat) |=> (!own && done)); // R6
endmodule

// File: rtl/rxdma_blen.sv
module rxdma_blen #(
    parameter int AW    = 16,
    parameter int LW    = 6,
    parameter int BMAX  = 16,
    parameter int LEN_W = $clog2(BMAX+1)
) (
    input  logic [LW-1:0]    level,
    input  logic [AW-1:0]    cur,
    input  logic [AW-1:0]    lim,
    output logic [LEN_W-1:0] len
);
    logic [AW-1:0] room, lv, cap, m;

    always_comb begin
        room = lim - cur;
        lv   = AW'(level);
        cap  = AW'(BMAX);
        m    = (lv < cap) ? lv : cap;
        m    = (room < m) ? room : m;
        len  = LEN_W'(m);
    end
endmodule

// File: rtl/rxdma_dbuf.sv
module rxdma_dbuf
    import rxdma_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LW    = 6,
    parameter int BMAX  = 16,
    parameter int LEN_W = $clog2(BMAX+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [AW-1:0]    reg_wdata,
    output logic [AW-1:0]    reg_rdata,
    input  logic             rx_timeout,
    input  logic             rx_exc,
    input  logic [LW-1:0]    fifo_level,
    output logic             fifo_pop,
    output logic [LEN_W-1:0] fifo_pop_len,
    output logic             fifo_drop,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic [LEN_W-1:0] mem_len,
    input  logic             mem_ack,
    input  logic             mem_err,
    output logic             irq
);
    rx_state_e state, next;
    logic sel, flip;
    logic pend_to, pend_ex, isr_be;

    logic          own_a [2];
    logic          done_a [2];
    logic          err_a [2];
    logic [AW-1:0] start_a [2];
    logic [AW-1:0] cur_a [2];
    logic [AW-1:0] lim_a [2];
    logic          adv_a [2];
    logic          close_a [2];
    logic          seterr_a [2];
    logic [AW-1:0] adv_amt;
    logic [LEN_W-1:0] blen;

    logic cmd_wr, any_pend, cur_full;
    logic do_adv, do_close, do_err;

    assign cmd_wr   = reg_we && (reg_addr == IDX_CMD);
    assign any_pend = pend_to || pend_ex;
    assign cur_full = (cur_a[sel] == lim_a[sel]);

    for (genvar i = 0; i < 2; i++) begin : g_buf
        localparam logic [3:0] BASE = 4'(i * 4);
        assign adv_a[i]    = do_adv   && (sel == 1'(i));
        assign close_a[i]  = do_close && (sel == 1'(i));
        assign seterr_a[i] = do_err   && (sel == 1'(i));
        rxdma_buf #(.AW(AW)) i_buf (
            .clk(clk), .rst_n(rst_n),
            .wr_start(reg_we && reg_addr == BASE),
            .wr_lim(reg_we && reg_addr == (BASE | 4'd1)),
            .wr_stat(reg_we && reg_addr == (BASE | 4'd2)),
            .wdata(reg_wdata),
            .adv(adv_a[i]), .adv_amt(adv_amt),
            .close(close_a[i]), .set_err(seterr_a[i]),
            .own(own_a[i]), .done(done_a[i]), .err(err_a[i]),
            .start_addr(start_a[i]), .cur_addr(cur_a[i]), .lim_addr(lim_a[i])
        );
    end

    rxdma_blen #(.AW(AW), .LW(LW), .BMAX(BMAX), .LEN_W(LEN_W)) i_blen (
        .level(fifo_level), .cur(cur_a[sel]), .lim(lim_a[sel]), .len(blen)
    );

    // next-state decision
    always_comb begin
        next = state;
        unique case (state)
            S_HOLD:  if (any_pend) next = S_INTR;
                     else if (own_a[sel]) next = S_READY;
            S_READY: if (any_pend) next = S_INTR;
                     else if (!own_a[sel]) next = S_HOLD;
                     else if (!cur_full && blen != '0) next = S_BURST;
            S_BURST: if (mem_err) next = S_INTR;
                     else if (mem_ack) next = S_READY;
            S_INTR:  if (cmd_wr) next = S_READY;
        endcase
    end

    // per-state outputs and buffer controls
    always_comb begin
        do_adv = 1'b0; do_close = 1'b0; do_err = 1'b0; flip = 1'b0;
        fifo_pop = 1'b0; fifo_drop = 1'b0; adv_amt = '0;
        fifo_pop_len = mem_len;
        unique case (state)
            S_HOLD: ;
            S_READY: if (!any_pend && own_a[sel] && cur_full) begin
                do_close = 1'b1;
                flip     = 1'b1;
            end
            S_BURST: if (mem_err) begin
                do_err = 1'b1;
            end else if (mem_ack) begin
                do_adv   = 1'b1;
                adv_amt  = AW'(mem_len);
                fifo_pop = 1'b1;
            end
            S_INTR: if (cmd_wr) begin
                adv_amt   = AW'(reg_wdata[7:0]);
                do_adv    = (reg_wdata[7:0] != 8'd0);
                fifo_drop = reg_wdata[CMD_DISC_BIT];
                do_close  = reg_wdata[CMD_TERM_BIT];
                flip      = reg_wdata[CMD_TERM_BIT];
            end
        endcase
    end

    // state register and latched request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_HOLD; sel <= 1'b0;
            mem_req <= 1'b0; mem_addr <= '0; mem_len <= '0;
            pend_to <= 1'b0; pend_ex <= 1'b0; isr_be <= 1'b0;
        end else begin
            state   <= next;
            mem_req <= (next == S_BURST);
            if (flip) sel <= ~sel;
            if (state == S_READY && next == S_BURST) begin
                mem_addr <= cur_a[sel];
                mem_len  <= blen;
            end
            if (state == S_INTR && cmd_wr) begin
                pend_to <= 1'b0; pend_ex <= 1'b0; isr_be <= 1'b0;
            end else begin
                if (rx_timeout) pend_to <= 1'b1;
                if (rx_exc)     pend_ex <= 1'b1;
                if (do_err)     isr_be  <= 1'b1;
            end
        end
    end

    assign irq = (state == S_INTR);

    // host read mux
    always_comb begin
        reg_rdata = '0;
        if (!reg_addr[3]) begin
            unique case (reg_addr[1:0])
                2'd0: reg_rdata = start_a[reg_addr[2]];
                2'd1: reg_rdata = lim_a[reg_addr[2]];
                2'd2: reg_rdata = AW'({err_a[reg_addr[2]], done_a[reg_addr[2]], own_a[reg_addr[2]]});
                2'd3: reg_rdata = cur_a[reg_addr[2]];
            endcase
        end else if (reg_addr == IDX_ISR) begin
            reg_rdata = AW'({sel, pend_ex, isr_be, pend_to});
        end
    end

    AST_REQ_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> own_a[sel]); // R3
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr) && $stable(mem_len))); // R4
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0 && mem_len <= LEN_W'(BMAX))); // R4
    AST_IRQ_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !mem_req); // R7
    AST_ERR_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err) |-> !fifo_pop); // R12
    AST_ERR_HOLDS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err) |=> (cur_a[sel] == $past(mem_addr))); // R12
    AST_PEND_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READY && any_pend) |=> irq); // R7
endmodule

// File: tb/test_rxdma_dbuf.sv
module test_rxdma_dbuf;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16, LW = 6, LEN_W = 5;

    logic clk = 0, rst_n = 0;
    logic reg_we = 0;
    logic [3:0] reg_addr = 0;
    logic [AW-1:0] reg_wdata = 0, reg_rdata;
    logic rx_timeout = 0, rx_exc = 0;
    logic [LW-1:0] fifo_level;
    logic fifo_pop, fifo_drop, mem_req, irq;
    logic [LEN_W-1:0] fifo_pop_len, mem_len;
    logic [AW-1:0] mem_addr;
    logic mem_ack = 0, mem_err = 0;

    int bytes_in = 0, bytes_out = 0, drops = 0;
    int errors = 0, checks = 0;
    logic done_flag = 0;

    assign fifo_level = (bytes_in > bytes_out) ? LW'(bytes_in - bytes_out) : '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (fifo_pop) bytes_out <= bytes_out + int'(fifo_pop_len);
        if (fifo_drop) drops <= drops + 1;
    end

    rxdma_dbuf i_rxdma_dbuf (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_timeout(rx_timeout),
        .rx_exc(rx_exc), .fifo_level(fifo_level), .fifo_pop(fifo_pop),
        .fifo_pop_len(fifo_pop_len), .fifo_drop(fifo_drop), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_ack(mem_ack),
        .mem_err(mem_err), .irq(irq)
    );

    // {write, index, data, expected read}
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 4'h0, 16'h0000, 16'h0000},
        {1'b0, 4'h2, 16'h0000, 16'h0000},
        {1'b0, 4'h6, 16'h0000, 16'h0000},
        {1'b0, 4'h9, 16'h0000, 16'h0000},
        {1'b1, 4'h0, 16'h0100, 16'h0000},
        {1'b1, 4'h1, 16'h0120, 16'h0000},
        {1'b1, 4'h4, 16'h0200, 16'h0000},
        {1'b1, 4'h5, 16'h0208, 16'h0000},
        {1'b0, 4'h0, 16'h0000, 16'h0100},
        {1'b0, 4'h3, 16'h0000, 16'h0100},
        {1'b0, 4'h1, 16'h0000, 16'h0120},
        {1'b0, 4'h7, 16'h0000, 16'h0200}
    };

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input int exp);
        int v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic pulse_to();
        @(negedge clk); rx_timeout = 1; @(negedge clk); rx_timeout = 0;
    endtask

    task automatic pulse_ex();
        @(negedge clk); rx_exc = 1; @(negedge clk); rx_exc = 0;
    endtask

    task automatic serve(input string req, input int ea, input int el, input logic fail);
        @(negedge clk);
        for (int k = 0; k < 50 && !mem_req; k++) @(negedge clk);
        chk({req, " req"}, int'(mem_req), 1);
        chk({req, " addr"}, int'(mem_addr), ea);
        chk({req, " len"}, int'(mem_len), el);
        if (fail) mem_err = 1; else mem_ack = 1;
        @(negedge clk);
        mem_err = 0; mem_ack = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, s;
        idle(3);
        rst_n = 1;
        idle(1);
        chk("R1 irq", int'(irq), 0);
        chk("R1 mem_req", int'(mem_req), 0);

        // R1/R2 register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][36]) wr(VEC[i][35:32], VEC[i][31:16]);
            else rdchk(i < 4 ? "R1 reset reg" : "R2 reg map", VEC[i][35:32], int'(VEC[i][15:0]));
        end

        // R3: data but no ownership
        bytes_in = 40;
        idle(6);
        chk("R3 no req unowned", int'(mem_req), 0);

        // R4/R5/R6: two bursts fill A, then switch to unowned B
        wr(4'h2, 16'h0001);
        serve("R4 burst1", 'h100, 16, 0);
        serve("R4 burst2", 'h110, 16, 0);
        idle(4);
        chk("R5 pop count", bytes_out, 32);
        rdchk("R6 A status closed", 4'h2, 2);
        rdchk("R6 active is B", 4'h9, 8);
        chk("R3 hold on B", int'(mem_req), 0);

        wr(4'h6, 16'h0001);
        serve("R4 room limited", 'h200, 8, 0);
        idle(4);
        rdchk("R6 B closed", 4'h6, 2);
        rdchk("R6 back to A", 4'h9, 0);

        // R12: bus error and retry into next buffer
        wr(4'h0, 16'h0300); wr(4'h1, 16'h0340); wr(4'h2, 16'h0001);
        wr(4'h4, 16'h0400); wr(4'h5, 16'h0440); wr(4'h6, 16'h0001);
        bytes_in = bytes_in + 20;
        serve("R12 failing burst", 'h300, 16, 1);
        idle(2);
        chk("R12 irq", int'(irq), 1);
        rdchk("R12 isr", 4'h9, 2);
        rdchk("R12 A status err", 4'h2, 5);
        rdchk("R12 cur held", 4'h3, 'h300);
        chk("R12 no pop", int'(fifo_level), 20);
        wr(4'h8, 16'h0200);
        chk("R8 irq cleared", int'(irq), 0);
        serve("R12 retry in B", 'h400, 16, 0);
        serve("R4 tail", 'h410, 4, 0);
        idle(2);
        rdchk("R9 A closed after terminate", 4'h2, 6);
        rd(4'h7, v); rd(4'h4, s);
        chk("R13 valid bytes", v - s, 'h14);

        // R7/R11/R8: timeout, gap, ignored command
        pulse_to();
        idle(2);
        chk("R7 irq", int'(irq), 1);
        rdchk("R7 isr timeout", 4'h9, 9);
        rdchk("R7 own kept", 4'h6, 1);
        wr(4'h8, 16'h0004);
        rdchk("R11 gap", 4'h7, 'h418);
        chk("R8 irq low", int'(irq), 0);
        wr(4'h8, 16'h0008);
        rdchk("R8 ignored outside irq", 4'h7, 'h418);
        wr(4'h8, 16'h0000);
        rdchk("R11 zero command no move", 4'h7, 'h418);

        // R10: discard
        pulse_ex();
        idle(2);
        rdchk("R7 isr exception", 4'h9, 'hC);
        wr(4'h8, 16'h0100);
        idle(1);
        chk("R10 drop pulse", drops, 1);
        rdchk("R10 cur unchanged", 4'h7, 'h418);

        // R9: terminate + discard, switch to unowned A
        pulse_to();
        idle(2);
        wr(4'h8, 16'h0300);
        idle(3);
        chk("R10 drop with terminate", drops, 2);
        rdchk("R9 B closed", 4'h6, 2);
        rdchk("R9 switched to A", 4'h9, 0);

        // R11 clamp: gap past the limit closes A, both unowned stops DMA
        wr(4'h0, 16'h0500); wr(4'h1, 16'h0504); wr(4'h2, 16'h0001);
        pulse_ex();
        idle(2);
        wr(4'h8, 16'h000A);
        idle(4);
        rdchk("R11 clamp at limit", 4'h3, 'h504);
        rdchk("R6 A closed at limit", 4'h2, 2);
        bytes_in = bytes_out + drops + 5;
        idle(6);
        chk("R9 stopped both unowned", int'(mem_req), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done_flag = 1;
        $finish;
    end
endmodule